// File: doc/BRIEF.md
# Event-to-Task Routing Matrix

This block links hardware event strobes to hardware task triggers without software involvement. It has a set of independent routing channels. Each channel names one line of a wide event pulse bus and one line of a wide task pulse bus. While the channel is enabled and the matrix clock gate is on, every cycle in which the chosen event line is high produces a one-cycle pulse on the chosen task line one clock later. When several channels aim at the same task line, their pulses merge by OR.

Software configures the matrix through a simple single-cycle register port. Each channel has its own event-ID and task-ID registers. Channel enables are kept in two 32-bit banks. Software can change them only by writing one-bits to a set register or a clear register, so it never needs a read-modify-write sequence. The current enable bits of each bank can be read back. A global gate bit turns the whole matrix on or off.

Top module: `evt_route_matrix`

## Requirements
- R1: After reset all channel enables are 0, the global gate is 0, every event ID and task ID reads 0, and the task bus is all zeros.
- R2: Channel c sits at bit (c mod 32) of bank (c / 32). Writing a 1 to a bit of bank 0's set register (address 0x01) or bank 1's set register (0x04) enables that channel. Writing a 1 to the matching bit of the clear register (0x02 for bank 0, 0x05 for bank 1) disables it. Bits written as 0 leave their channels unchanged.
- R3: Reading 0x03 returns bank 0's enable bits, and reading 0x06 returns bank 1's. Bits for channels that are not implemented read 0 and cannot be set. Writes to the status addresses have no effect.
- R4: When an enabled channel samples its event line high at a clock edge while the gate is on, its task line is high for exactly the following cycle.
- R5: Event line k is selected by event ID k, and task line k by task ID k. An ID of 0 is unconnected. An ID equal to or greater than the bus width never matches.
- R6: When several enabled channels fire onto the same task line in the same cycle, that line shows one pulse. Channels that target different task lines pulse those lines together.
- R7: While the global gate (bit 0 at address 0x00) is 0, no task pulse is produced.
- R8: A write to a channel's event or task ID takes effect from the next cycle and produces no task pulse by itself.
- R9: A disabled channel produces no task pulse, whatever its event line does.
- R10: Register map: the event ID of channel c is at address 0x40 + 2c and its task ID at 0x41 + 2c. Both are readable and zero-extended. The gate is at 0x00 and reads back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| evtBus | input | EVT_W (64) | Event pulse lines; line 0 is unused |
| taskBus | output | TASK_W (64) | Registered task pulse lines; line 0 is never driven |

## Verification
The hardest situation to reach from the ports is the set of channels whose settings sit at the edge of what is legal: ID 0, IDs past the bus width, and enable bits for channels beyond the last one in bank 1. Each of these must stay silent, but an open or misdecoded selector would make some line pulse. The stimulus configures such channels next to ordinary ones that share task lines. It then walks event patterns that each light exactly one suspect line, so any leak shows up as an extra bit on the task bus. The stimulus also changes IDs while the event bus is idle and toggles the gate between pulses, to show that neither action produces a pulse of its own.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int CHIDX_W = 8;

  localparam logic [ADDR_W-1:0] A_GATE = 8'h00;
  localparam logic [ADDR_W-1:0] A_SET0 = 8'h01;
  localparam logic [ADDR_W-1:0] A_CLR0 = 8'h02;
  localparam logic [ADDR_W-1:0] A_STA0 = 8'h03;
  localparam logic [ADDR_W-1:0] A_SET1 = 8'h04;
  localparam logic [ADDR_W-1:0] A_CLR1 = 8'h05;
  localparam logic [ADDR_W-1:0] A_STA1 = 8'h06;
  localparam logic [ADDR_W-1:0] A_IDS  = 8'h40;

  typedef struct packed {
    logic                    gateWr;
    logic                    gateVal;
    logic [1:0][REG_W-1:0]   setMask;
    logic [1:0][REG_W-1:0]   clrMask;
    logic                    idWr;
    logic                    idIsTask;
    logic [CHIDX_W-1:0]      idCh;
    logic [REG_W-1:0]        idVal;
  } ctrlStrobes_t;
endpackage

// File: rtl/evr_ctrl.sv
module evr_ctrl
  import evr_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int ID_W   = 8
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output ctrlStrobes_t      strobes,
  input  logic              gateOn,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [ID_W-1:0]   evtId  [NUM_CH],
  input  logic [ID_W-1:0]   taskId [NUM_CH]
);
  localparam int ID_SPAN = 2 * NUM_CH;

  logic [2*REG_W-1:0] enPad;
  logic [ADDR_W-1:0]  idOff;
  logic               inIdSpan;
  logic [CHIDX_W-1:0] chSel;

  assign enPad    = (2*REG_W)'(chEnable);
  assign idOff    = regAddr - A_IDS;
  assign inIdSpan = (regAddr >= A_IDS) && (int'(idOff) < ID_SPAN);
  assign chSel    = CHIDX_W'(idOff >> 1);

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      unique case (regAddr)
        A_GATE: begin
          strobes.gateWr  = 1'b1;
          strobes.gateVal = regWrData[0];
        end
        A_SET0: strobes.setMask[0] = regWrData;
        A_CLR0: strobes.clrMask[0] = regWrData;
        A_SET1: strobes.setMask[1] = regWrData;
        A_CLR1: strobes.clrMask[1] = regWrData;
        default: begin
          if (inIdSpan) begin
            strobes.idWr     = 1'b1;
            strobes.idIsTask = idOff[0];
            strobes.idCh     = chSel;
            strobes.idVal    = regWrData;
          end
        end
      endcase
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      A_GATE: regRdData = REG_W'(gateOn);
      A_STA0: regRdData = enPad[REG_W-1:0];
      A_STA1: regRdData = enPad[2*REG_W-1:REG_W];
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (inIdSpan && int'(chSel) == c)
            regRdData = idOff[0] ? REG_W'(taskId[c]) : REG_W'(evtId[c]);
        end
      end
    endcase
  end
endmodule

// File: rtl/evr_core.sv
module evr_core
  import evr_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int EVT_W  = 64,
  parameter int TASK_W = 64,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [EVT_W-1:0]  evtBus,
  output logic [TASK_W-1:0] taskBus,
  output logic              gateOn,
  output logic [NUM_CH-1:0] chEnable,
  output logic [ID_W-1:0]   evtId  [NUM_CH],
  output logic [ID_W-1:0]   taskId [NUM_CH]
);
  localparam int EVT_IDX_W  = $clog2(EVT_W);
  localparam int TASK_IDX_W = $clog2(TASK_W);

  logic [NUM_CH-1:0] chFire;
  logic [TASK_W-1:0] taskNext;

  always_ff @(posedge clk) begin
    if (rst) gateOn <= 1'b0;
    else if (strobes.gateWr) gateOn <= strobes.gateVal;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BANK = c / REG_W;
    localparam int BIT  = c % REG_W;

    always_ff @(posedge clk) begin
      if (rst) chEnable[c] <= 1'b0;
      else if (strobes.clrMask[BANK][BIT]) chEnable[c] <= 1'b0;
      else if (strobes.setMask[BANK][BIT]) chEnable[c] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        evtId[c]  <= '0;
        taskId[c] <= '0;
      end else if (strobes.idWr && int'(strobes.idCh) == c) begin
        if (strobes.idIsTask) taskId[c] <= strobes.idVal[ID_W-1:0];
        else                  evtId[c]  <= strobes.idVal[ID_W-1:0];
      end
    end

    logic evtLegal;
    assign evtLegal  = (evtId[c] != '0) && (int'(evtId[c]) < EVT_W);
    assign chFire[c] = gateOn && chEnable[c] && evtLegal &&
                       evtBus[evtId[c][EVT_IDX_W-1:0]];
  end

  always_comb begin
    taskNext = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chFire[c] && taskId[c] != '0 && int'(taskId[c]) < TASK_W)
        taskNext[taskId[c][TASK_IDX_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) taskBus <= '0;
    else     taskBus <= taskNext;
  end
endmodule

// File: rtl/evt_route_matrix.sv
module evt_route_matrix
  import evr_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int EVT_W  = 64,
  parameter int TASK_W = 64,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [EVT_W-1:0]  evtBus,
  output logic [TASK_W-1:0] taskBus
);
  ctrlStrobes_t      strobes;
  logic              gateOn;
  logic [NUM_CH-1:0] chEnable;
  logic [ID_W-1:0]   evtId  [NUM_CH];
  logic [ID_W-1:0]   taskId [NUM_CH];

  evr_ctrl #(.NUM_CH(NUM_CH), .ID_W(ID_W)) i_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .strobes(strobes), .gateOn(gateOn),
    .chEnable(chEnable), .evtId(evtId), .taskId(taskId)
  );

  evr_core #(.NUM_CH(NUM_CH), .EVT_W(EVT_W), .TASK_W(TASK_W), .ID_W(ID_W)) i_core (
    .clk(clk), .rst(rst), .strobes(strobes), .evtBus(evtBus),
    .taskBus(taskBus), .gateOn(gateOn), .chEnable(chEnable),
    .evtId(evtId), .taskId(taskId)
  );
endmodule

// File: rtl/evr_checker.sv
module evr_checker #(
  parameter int NUM_CH = 50,
  parameter int EVT_W  = 64,
  parameter int TASK_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic [7:0]        regAddr,
  input logic [31:0]       regWrData,
  input logic [EVT_W-1:0]  evtBus,
  input logic [TASK_W-1:0] taskBus,
  input logic              gateOn,
  input logic [NUM_CH-1:0] chEnable
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (taskBus == '0 && chEnable == '0 && !gateOn));

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (rst) !gateOn |=> taskBus == '0);

  // R9
  all_disabled_chk: assert property (@(posedge clk) disable iff (rst) (chEnable == '0) |=> taskBus == '0);

  // R4
  cause_chk: assert property (@(posedge clk) disable iff (rst) (evtBus == '0) |=> taskBus == '0);

  // R2
  clear_ch0_chk: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == 8'h02 && regWrData[0]) |=> !chEnable[0]);

  // R5
  line0_chk: assert property (@(posedge clk) disable iff (rst) !taskBus[0]);
endmodule

bind evt_route_matrix evr_checker #(.NUM_CH(NUM_CH), .EVT_W(EVT_W), .TASK_W(TASK_W)) i_chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .evtBus(evtBus), .taskBus(taskBus), .gateOn(gateOn), .chEnable(chEnable)
);

// File: tb/test_evt_route_matrix.sv
module test_evt_route_matrix;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] evtBus = '0;
  logic [63:0] taskBus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_route_matrix i_evt_route_matrix (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtBus(evtBus), .taskBus(taskBus)
  );

  // event pattern, expected task bus
  localparam logic [63:0] VEC_EVT [NVEC] = '{
    64'h8, 64'h10, 64'h18, 64'h400, 64'h1, 64'h40, 64'h1000, 64'h800, 64'h408, 64'h2000};
  localparam logic [63:0] VEC_EXP [NVEC] = '{
    64'h20, 64'h20, 64'h20, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'h0, 64'h0,
    64'h8000_0000_0000_0020, 64'h0000_0100_0000_0000};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // drive an event for one cycle, check the pulse then its end
  task automatic fire(logic [63:0] e, logic [63:0] exp, string req);
    @(negedge clk);
    evtBus = e;
    @(negedge clk);
    evtBus = '0;
    chk(req, taskBus, exp);
    @(negedge clk);
    chk("R4 single-cycle", taskBus, 64'h0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 task bus", taskBus, 64'h0);
    rd(8'h00, r); chk("R1 gate", 64'(r), 64'h0);
    rd(8'h03, r); chk("R1 bank0", 64'(r), 64'h0);
    rd(8'h83, r); chk("R1 task id ch33", 64'(r), 64'h0);

    // configure channels
    wr(8'h40, 3);  wr(8'h41, 5);    // ch0
    wr(8'h42, 4);  wr(8'h43, 5);    // ch1 same task
    wr(8'h44, 0);  wr(8'h45, 7);    // ch2 unconnected event
    wr(8'h46, 6);  wr(8'h47, 0);    // ch3 unconnected task
    wr(8'h48, 11); wr(8'h49, 80);   // ch4 task beyond width
    wr(8'h4A, 12); wr(8'h4B, 20);   // ch5 left disabled
    wr(8'h4C, 13); wr(8'h4D, 40);   // ch6
    wr(8'h82, 10); wr(8'h83, 63);   // ch33
    wr(8'hA2, 70); wr(8'hA3, 9);    // ch49 event beyond width
    wr(8'h01, 32'h5F);
    wr(8'h04, 32'h0002_0002);
    wr(8'h00, 1);

    rd(8'h03, r); chk("R2 bank0 status", 64'(r), 64'h5F);
    rd(8'h06, r); chk("R2 bank1 status ch33 ch49", 64'(r), 64'h0002_0002);
    wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFC_0000);
    rd(8'h06, r); chk("R3 unimplemented and read-only", 64'(r), 64'h0002_0002);
    rd(8'h82, r); chk("R10 event id ch33", 64'(r), 64'd10);
    rd(8'hA3, r); chk("R10 task id ch49", 64'(r), 64'd9);
    rd(8'h00, r); chk("R10 gate readback", 64'(r), 64'h1);

    // R4 R5 R6 R9 table walk
    for (int i = 0; i < NVEC; i++) fire(VEC_EVT[i], VEC_EXP[i], "R4/R5/R6/R9 vector");

    // R2 clear only ch0, zero bits no effect
    wr(8'h02, 32'h1);
    wr(8'h01, 32'h0);
    rd(8'h03, r); chk("R2 clear ch0", 64'(r), 64'h5E);
    fire(64'h8, 64'h0, "R9 ch0 disabled");
    fire(64'h10, 64'h20, "R2 ch1 untouched");

    // R7 gate off
    wr(8'h00, 0);
    fire(64'h410, 64'h0, "R7 gate off");
    wr(8'h00, 1);
    fire(64'h410, 64'h8000_0000_0000_0020, "R7 gate back on");

    // R8 retarget ch1 while idle
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 8'h43; regWrData = 21;
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R8 no spurious pulse", taskBus, 64'h0);
    @(negedge clk);
    chk("R8 no spurious pulse later", taskBus, 64'h0);
    fire(64'h10, 64'h0000_0000_0020_0000, "R8 new task id");

    summary();
  end
endmodule